// File: doc/BRIEF.md
# Truncating Integer-to-Float Converter

This block turns a 32-bit two's-complement integer into an IEEE-754 single-precision value. It always rounds toward zero, and no rounding-mode setting anywhere in the chip can change that. Each operation carries a predicate bit, which is the least significant bit of its guard operand. A predicated-off operation still uses an issue slot. It leaves the pipeline with no result and with no effect on the exception state.

Operations come in on a valid/ready stream together with a destination tag, and results go out on a valid/ready stream with the same tag. The rules for back-pressure are as follows. An input is taken only on a cycle where `in_valid` and `in_ready` are both high. A result is transferred only on a cycle where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the output holds steady and the whole pipeline freezes, so `in_ready` is low.

When there is no stall, the latency is three cycles and one operation can issue every cycle. Each transferred result carries an inexact indication. That indication is ORed into a sticky five-bit status register in the same cycle as the transfer. Other floating-point units can also set status bits through a port. Software can overwrite the register, and any flag sets that arrive in the same cycle still win over the written value.

Top module: `itof_trunc_unit`

## Requirements
- R1: A transferred result has sign in bit 31, the exponent biased by 127 in bits 30:23, and the 23-bit fraction in bits 22:0. It equals the input value truncated toward zero; for example 3 becomes 0x40400000, -1 becomes 0xbf800000, and 0x80000000 becomes 0xcf000000.
- R2: An input of zero yields 0x00000000 with `out_inexact` low.
- R3: `out_inexact` is high exactly when nonzero magnitude bits fall below the 24-bit significand. Examples are 0x7fffffff and 0x7ffffff1, which both give 0x4effffff. The unit itself only ever sets status bit 0, which is the inexact flag. Status bits 1 to 4 (underflow, overflow, divide-by-zero, invalid) are never set by the unit.
- R4: With `out_ready` held high, an operation accepted in cycle t appears on the output in cycle t+3. Operations can be accepted in consecutive cycles.
- R5: An operation accepted with `in_guard_lsb` low produces no output transfer and does not change `status_flags`.
- R6: While `out_valid` is high and `out_ready` is low, `out_data`, `out_tag` and `out_inexact` hold and `in_ready` is low. No result is lost or reordered.
- R7: When a transfer has `out_inexact` high, status bit 0 is set from the next cycle onward. Without a software write, status bits never clear. A result that is held back sets nothing.
- R8: Any bit that is high on `ext_flag_set` in a cycle is set in `status_flags` from the next cycle onward.
- R9: When `sw_wr_en` is high, the next status value equals `sw_wr_data` ORed with that cycle's external and own flag sets.
- R10: `out_tag` equals the `in_tag` that was presented with the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken |
| in_data | input | 32 | Signed integer source |
| in_guard_lsb | input | 1 | Predicate; 0 squashes the operation |
| in_tag | input | 5 | Destination tag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Single-precision result |
| out_tag | output | 5 | Tag of the result |
| out_inexact | output | 1 | This result discarded nonzero bits |
| ext_flag_set | input | 5 | Same-cycle flag sets from other units |
| sw_wr_en | input | 1 | Software status write |
| sw_wr_data | input | 5 | Value for the software write |
| status_flags | output | 5 | Sticky flags: bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid |

## Verification
The bench runs a sweep over every power of two, each power of two plus one and minus one, and their negations. It then runs about two thousand pseudo-random values, and every result is compared against a float that the bench builds arithmetically. This sweep catches several faults:
- An off-by-one in the leading-zero count, which would shift the exponent.
- A round-up, which would turn 0x7fffffff into 2^31.
- An inexact test that looks at the wrong bits, which would flag exact values such as 0x80000000.

Random back-pressure during the sweep exposes any stage that advances while the output is stalled, which would drop or duplicate results. Predicated-off operations check that a squashed operation produces neither a transfer nor a sticky flag. Directed status sequences check the sticky behaviour when a software write collides with a transfer or with an external set. A design that let the write win would lose those flags.

// File: rtl/itof_pkg.sv
package itof_pkg;
  localparam int NFLAG   = 5;
  localparam int FLG_INX = 0;
  localparam int FLG_UNF = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_DVZ = 3;
  localparam int FLG_INV = 4;
  typedef logic [NFLAG-1:0] flags_t;
endpackage

// File: rtl/itof_magnitude.sv
module itof_magnitude #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x_i,
  output logic              sign_o,
  output logic              zero_o,
  output logic [DATA_W-1:0] mag_o
);
  // The most negative value maps onto itself, which is its correct unsigned magnitude.
  assign sign_o = x_i[DATA_W-1];
  assign zero_o = (x_i == '0);
  assign mag_o  = sign_o ? (~x_i + DATA_W'(1)) : x_i;
endmodule

// File: rtl/itof_normalize.sv
module itof_normalize #(
  parameter int DATA_W = 32,
  localparam int LZW   = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] mag_i,
  output logic [LZW-1:0]    lz_o,
  output logic [DATA_W-1:0] norm_o
);
  logic found;

  always_comb begin
    lz_o  = LZW'(DATA_W);
    found = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (!found && mag_i[i]) begin
        lz_o  = LZW'(DATA_W - 1 - i);
        found = 1'b1;
      end
    end
  end

  assign norm_o = mag_i << lz_o;
endmodule

// File: rtl/itof_pack.sv
module itof_pack #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  localparam int LZW   = $clog2(DATA_W + 1),
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1,
  localparam int DROP_W = DATA_W - 1 - MAN_W,
  localparam int FP_W  = 1 + EXP_W + MAN_W
) (
  input  logic              sign_i,
  input  logic              zero_i,
  input  logic [LZW-1:0]    lz_i,
  input  logic [DATA_W-1:0] norm_i,
  output logic [FP_W-1:0]   word_o,
  output logic              inexact_o
);
  logic [EXP_W-1:0] exp_v;
  logic [MAN_W-1:0] man_v;
  logic [DROP_W-1:0] drop_v;

  // Top bit of norm_i is the hidden one; fraction follows; the rest is cut off.
  assign exp_v  = EXP_W'(BIAS + DATA_W - 1) - EXP_W'(lz_i);
  assign man_v  = norm_i[DATA_W-2 -: MAN_W];
  assign drop_v = norm_i[DROP_W-1:0];

  assign word_o    = zero_i ? '0 : {sign_i, exp_v, man_v};
  assign inexact_o = !zero_i && (|drop_v);
endmodule

// File: rtl/itof_sticky_status.sv
module itof_sticky_status
  import itof_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t own_set_i,
  input  flags_t ext_set_i,
  input  logic   sw_wr_en_i,
  input  flags_t sw_wr_data_i,
  output flags_t status_o
);
  flags_t base;

  assign base = sw_wr_en_i ? sw_wr_data_i : status_o;

  always_ff @(posedge clk) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= base | ext_set_i | own_set_i;
  end

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R8
  ext_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_set_i) |=> ((status_o & $past(ext_set_i)) == $past(ext_set_i)));
endmodule

// File: rtl/itof_trunc_unit.sv
module itof_trunc_unit
  import itof_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_guard_lsb,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_inexact,
  input  logic [NFLAG-1:0]  ext_flag_set,
  input  logic              sw_wr_en,
  input  logic [NFLAG-1:0]  sw_wr_data,
  output logic [NFLAG-1:0]  status_flags
);
  localparam int LZW  = $clog2(DATA_W + 1);
  localparam int FP_W = 1 + EXP_W + MAN_W;

  logic advance, take, fire;

  // stage 0 combinational: sign and magnitude
  logic              c0_sign, c0_zero;
  logic [DATA_W-1:0] c0_mag;

  itof_magnitude #(.DATA_W(DATA_W)) u_mag (
    .x_i(in_data), .sign_o(c0_sign), .zero_o(c0_zero), .mag_o(c0_mag)
  );

  // stage 1 registers
  logic              s1_v, s1_sign, s1_zero;
  logic [TAG_W-1:0]  s1_tag;
  logic [DATA_W-1:0] s1_mag;

  logic [LZW-1:0]    c1_lz;
  logic [DATA_W-1:0] c1_norm;

  itof_normalize #(.DATA_W(DATA_W)) u_norm (
    .mag_i(s1_mag), .lz_o(c1_lz), .norm_o(c1_norm)
  );

  // stage 2 registers
  logic              s2_v, s2_sign, s2_zero;
  logic [TAG_W-1:0]  s2_tag;
  logic [LZW-1:0]    s2_lz;
  logic [DATA_W-1:0] s2_norm;

  logic [FP_W-1:0]   c2_word;
  logic              c2_inexact;

  itof_pack #(.DATA_W(DATA_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
    .sign_i(s2_sign), .zero_i(s2_zero), .lz_i(s2_lz), .norm_i(s2_norm),
    .word_o(c2_word), .inexact_o(c2_inexact)
  );

  // one shared stall: the whole pipe freezes behind a held result
  assign advance  = !(out_valid && !out_ready);
  assign in_ready = advance;
  assign take     = in_valid && in_ready && in_guard_lsb;
  assign fire     = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_sign <= 1'b0; s1_zero <= 1'b0; s1_tag <= '0; s1_mag <= '0;
      s2_v <= 1'b0; s2_sign <= 1'b0; s2_zero <= 1'b0; s2_tag <= '0; s2_lz <= '0; s2_norm <= '0;
      out_valid <= 1'b0; out_data <= '0; out_tag <= '0; out_inexact <= 1'b0;
    end else if (advance) begin
      s1_v      <= take;
      s1_sign   <= c0_sign;
      s1_zero   <= c0_zero;
      s1_tag    <= in_tag;
      s1_mag    <= c0_mag;
      s2_v      <= s1_v;
      s2_sign   <= s1_sign;
      s2_zero   <= s1_zero;
      s2_tag    <= s1_tag;
      s2_lz     <= c1_lz;
      s2_norm   <= c1_norm;
      out_valid <= s2_v;
      out_data  <= DATA_W'(c2_word);
      out_tag   <= s2_tag;
      out_inexact <= c2_inexact && s2_v;
    end
  end

  // the flag update rides on the same handshake as the result write
  flags_t own_set;
  always_comb begin
    own_set          = '0;
    own_set[FLG_INX] = fire && out_inexact;
  end

  itof_sticky_status u_status (
    .clk(clk), .rst_n(rst_n), .own_set_i(own_set), .ext_set_i(ext_flag_set),
    .sw_wr_en_i(sw_wr_en), .sw_wr_data_i(sw_wr_data), .status_o(status_flags)
  );

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag) && $stable(out_inexact)));

  // R2
  zero_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_data[DATA_W-2:0] == '0) |-> !out_inexact);

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_guard_lsb) ##1 out_ready ##1 out_ready |=> out_valid);

  // R7
  flag_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_inexact) |=> status_flags[FLG_INX]);
endmodule

// File: tb/itof_trunc_unit_test.sv
module itof_trunc_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_guard_lsb = 1'b0, out_ready = 1'b1, sw_wr_en = 1'b0;
  logic [31:0] in_data = '0;
  logic [4:0]  in_tag = '0, ext_flag_set = '0, sw_wr_data = '0;
  logic        in_ready, out_valid, out_inexact;
  logic [31:0] out_data;
  logic [4:0]  out_tag, status_flags;

  always #5 clk = ~clk;

  itof_trunc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_guard_lsb(in_guard_lsb), .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_tag(out_tag), .out_inexact(out_inexact),
    .ext_flag_set(ext_flag_set), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .status_flags(status_flags)
  );

  int checks = 0, errors = 0, cyc = 0;
  int head = 0, tail = 0, retired = 0;
  bit lat_mode = 1'b1, bp_on = 1'b0, done = 1'b0;
  logic [31:0] q_data [0:4095];
  logic        q_inx  [0:4095];
  logic [4:0]  q_tag  [0:4095];
  int          q_cyc  [0:4095];
  logic [4:0]  tagc = '0;
  logic [31:0] bp_lfsr = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void ref_cvt(input logic [31:0] x, output logic [31:0] f, output logic inx);
    logic [63:0] m, mant;
    int p;
    logic s;
    inx = 1'b0;
    f = '0;
    if (x == 32'd0) return;
    s = x[31];
    m = s ? (64'h1_0000_0000 - {32'd0, x}) : {32'd0, x};
    p = 0;
    for (int b = 0; b < 32; b++) if (m[b]) p = b;
    if (p > 23) begin
      inx  = (m % (64'd1 << (p - 23))) != 64'd0;
      mant = (m >> (p - 23)) - (64'd1 << 23);
    end else begin
      mant = (m << (23 - p)) - (64'd1 << 23);
    end
    f = {s, 8'(127 + p), mant[22:0]};
  endfunction

  task automatic issue(input logic [31:0] x, input logic g);
    logic acc;
    logic [31:0] f;
    logic inx;
    @(negedge clk); #1;
    in_valid = 1'b1; in_data = x; in_guard_lsb = g; in_tag = tagc;
    acc = 1'b0;
    do begin
      #1;
      acc = in_ready;
      if (acc) begin
        if (g) begin
          ref_cvt(x, f, inx);
          q_data[tail % 4096] = f; q_inx[tail % 4096] = inx;
          q_tag[tail % 4096] = tagc; q_cyc[tail % 4096] = cyc;
          tail++;
        end
      end else begin
        @(negedge clk); #1;
      end
    end while (!acc);
    @(posedge clk); #1;
    in_valid = 1'b0;
    tagc = tagc + 5'd1;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    int guard_cnt = 0;
    while (head != tail && guard_cnt < 200) begin @(negedge clk); guard_cnt++; end
    wait_cycles(2);
  endtask

  task automatic finish_up;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: values at negedge+3 are those seen by the next rising edge
  always begin
    @(negedge clk); #3;
    if (rst_n && out_valid && out_ready) begin
      if (head == tail) begin
        chk(1'b0, "R5", "unexpected result", out_data, 32'h0);
      end else begin
        chk(out_data === q_data[head % 4096], "R1", "result value", out_data, q_data[head % 4096]);
        chk(out_inexact === q_inx[head % 4096], "R3", "inexact", {31'd0, out_inexact}, {31'd0, q_inx[head % 4096]});
        chk(out_tag === q_tag[head % 4096], "R10", "tag", {27'd0, out_tag}, {27'd0, q_tag[head % 4096]});
        if (lat_mode)
          chk(cyc == q_cyc[head % 4096] + 3, "R4", "latency", cyc, q_cyc[head % 4096] + 3);
        head++;
        retired++;
      end
    end
  end

  // random back-pressure
  always begin
    @(negedge clk); #1;
    if (bp_on) begin
      bp_lfsr = {bp_lfsr[30:0], bp_lfsr[31] ^ bp_lfsr[21] ^ bp_lfsr[1] ^ bp_lfsr[0]};
      out_ready = bp_lfsr[3] | bp_lfsr[7];
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_up();
    end
  end

  task automatic status_write(input logic [4:0] v);
    @(negedge clk); #1;
    sw_wr_en = 1'b1; sw_wr_data = v;
    @(negedge clk); #1;
    sw_wr_en = 1'b0;
  endtask

  initial begin
    logic [31:0] x;
    logic [31:0] held;
    int r0;
    wait_cycles(3);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #3;
    // reset state
    chk(out_valid === 1'b0, "R6", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk(in_ready === 1'b1, "R6", "reset in_ready", {31'd0, in_ready}, 32'd1);
    chk(status_flags === 5'd0, "R7", "reset status", {27'd0, status_flags}, 32'd0);

    // R1 R2 R3 R4 directed values, back to back
    issue(32'd3, 1'b1);
    issue(32'hffffffff, 1'b1);
    issue(32'hfffffffd, 1'b1);
    issue(32'h7fffffff, 1'b1);
    issue(32'h80000000, 1'b1);
    issue(32'h7ffffff1, 1'b1);
    issue(32'd0, 1'b1);
    drain();
    chk(status_flags === 5'b00001, "R3", "only inexact set by unit", {27'd0, status_flags}, 32'h1);

    // R5 guard false: no result, no flags
    status_write(5'd0);
    r0 = retired;
    issue(32'h7fffffff, 1'b0);
    issue(32'h0000ffff, 1'b1);
    issue(32'h7ffffff1, 1'b0);
    drain();
    chk(retired == r0 + 1, "R5", "squashed ops retired", retired, r0 + 1);
    chk(status_flags === 5'd0, "R5", "squashed ops leave status", {27'd0, status_flags}, 32'd0);

    // R6 stall: three ops fill the pipe, output holds, input blocked
    lat_mode = 1'b0;
    @(negedge clk); #1 out_ready = 1'b0;
    issue(32'h7fffffff, 1'b1);
    issue(32'd12345, 1'b1);
    issue(32'hff000001, 1'b1);
    wait_cycles(1); #3;
    held = out_data;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #2;
      chk(out_valid === 1'b1 && out_data === held, "R6", "held output", out_data, held);
      chk(in_ready === 1'b0, "R6", "in_ready low in stall", {31'd0, in_ready}, 32'd0);
    end
    chk(status_flags[0] === 1'b0, "R7", "held result sets nothing", {27'd0, status_flags}, 32'd0);
    // R9 software write collides with an inexact transfer
    @(negedge clk); #1;
    out_ready = 1'b1; sw_wr_en = 1'b1; sw_wr_data = 5'b00100;
    @(negedge clk); #1;
    sw_wr_en = 1'b0;
    #1;
    chk(status_flags === 5'b00101, "R9", "write ORed with own set", {27'd0, status_flags}, 32'h5);
    drain();

    // R8 external set, then R9 write colliding with external set
    @(negedge clk); #1 ext_flag_set = 5'b01010;
    @(negedge clk); #1 ext_flag_set = 5'd0;
    #1;
    chk(status_flags === 5'b01111, "R8", "external set merged", {27'd0, status_flags}, 32'hf);
    wait_cycles(3); #2;
    chk(status_flags === 5'b01111, "R7", "sticky holds", {27'd0, status_flags}, 32'hf);
    @(negedge clk); #1;
    sw_wr_en = 1'b1; sw_wr_data = 5'd0; ext_flag_set = 5'b10000;
    @(negedge clk); #1;
    sw_wr_en = 1'b0; ext_flag_set = 5'd0;
    #1;
    chk(status_flags === 5'b10000, "R9", "clear with same-cycle external set", {27'd0, status_flags}, 32'h10);
    status_write(5'd0);
    #1;
    chk(status_flags === 5'd0, "R9", "software clear", {27'd0, status_flags}, 32'd0);

    // R1 R3 sweep over powers of two and neighbours, with back-pressure
    bp_on = 1'b1;
    for (int k = 0; k < 32; k++) begin
      issue(32'd1 << k, 1'b1);
      issue(-(32'd1 << k), 1'b1);
      issue((32'd1 << k) - 32'd1, 1'b1);
      issue((32'd1 << k) + 32'd1, 1'b1);
      issue(~(32'd1 << k), 1'b1);
    end
    x = 32'h2545_f491;
    for (int i = 0; i < 2000; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      issue(x >> (i % 29), (i % 5) != 0);
    end
    @(negedge clk); #1 bp_on = 1'b0; out_ready = 1'b1;
    drain();
    chk(head == tail, "R6", "no result lost", head, tail);
    chk(status_flags[4:1] === 4'd0, "R3", "unit sets no other flag", {27'd0, status_flags}, 32'h1);
    chk(status_flags[0] === 1'b1, "R7", "inexact accumulated", {27'd0, status_flags}, 32'h1);
    finish_up();
  end
endmodule